// File: doc/BRIEF.md
# Sequential Booth Multiply-Accumulate Unit

This block is a compact, iterative multiplier for a 32-bit processor datapath. A one-cycle start pulse captures a multiplicand, a multiplier, an addend and a function select. The unit then retires one radix-2 Booth recoding step per clock. Each step looks at the current and the previous multiplier bit and adds the shifted multiplicand, subtracts it, or leaves the partial product alone. After the last step a single addition folds in the addend for multiply-accumulate, and the low word is registered.

Each operation has a fixed latency, so a sequencer can plan around it without waiting on a handshake. The result stays on the output until the next operation finishes. Sign and zero flags come with it, ready for a status update. Because only the low word is produced, the two's complement and unsigned interpretations of the operands give the same result.

Top module: `boothMac`

## Requirements
- R1: While rstN is low and after its release, doneO is 0, resultO is 0, flagNO is 0 and flagZO is 1.
- R2: With funcI = 0 (multiply), the result is bits 31:0 of opAI × opBI, and accI has no effect on it.
- R3: With funcI = 1 (multiply-accumulate), the result is bits 31:0 of opAI × opBI + accI.
- R4: A start is sampled on the rising edge at which startI is high and the unit is idle. Counting that edge as the first, doneO is high right after the 34th rising edge, and resultO carries the new value from then on.
- R5: doneO is high for exactly one clock cycle per accepted start.
- R6: A start that arrives while an operation is in progress is ignored. Its operands are not used, it causes no second doneO pulse, and it does not shift the timing of the running operation.
- R7: flagNO equals bit 31 of resultO, so it is valid while doneO is high.
- R8: flagZO is 1 exactly when resultO is all zeros, including a nonzero product plus addend that wraps to zero.
- R9: Between doneO pulses, resultO holds its last value.
- R10: A start raised in the same cycle that doneO is high is accepted, and its doneO follows after a further 34 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startI | input | 1 | Start request, sampled when idle |
| funcI | input | 1 | 0 = multiply, 1 = multiply-accumulate |
| opAI | input | 32 | Multiplicand |
| opBI | input | 32 | Multiplier (Booth-recoded) |
| accI | input | 32 | Addend used when funcI = 1 |
| doneO | output | 1 | One-cycle completion strobe |
| resultO | output | 32 | Low word of product (plus addend) |
| flagNO | output | 1 | Sign of resultO |
| flagZO | output | 1 | resultO is zero |

## Verification
A checker keeps its own record of which start was accepted and of its operands. On every cycle it checks three things: that doneO appears only on the 34th edge of an accepted operation and always does; that the strobe never lasts two cycles; and that the result then equals a product computed with a plain multiply, plus the addend when one is selected. It also checks that resultO never moves except when a completion rises. The directed scenarios cover the rest: flag values on negative, zero and wrapping results, a start ignored mid-operation, and back-to-back starts issued on the completion cycle.

// File: rtl/boothMacPkg.sv
package boothMacPkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;    // capture operands, clear partial product
    logic step;    // one Booth recoding step
    logic finish;  // fold in addend and register the result
  } mulCtrlT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_ACC  = 2'd2
  } mulStateT;

endpackage

// File: rtl/boothRecode.sv
// Radix-2 Booth selection: picks +M, -M or 0 from a multiplier bit pair.
module boothRecode #(
  parameter int W = 32
) (
  input  logic         curBit,
  input  logic         prevBit,
  input  logic [W-1:0] mcand,
  output logic [W-1:0] addend
);
  always_comb begin
    unique case ({curBit, prevBit})
      2'b01:   addend = mcand;
      2'b10:   addend = ~mcand + W'(1);
      default: addend = '0;
    endcase
  end
endmodule

// File: rtl/boothMacCtrl.sv
module boothMacCtrl
  import boothMacPkg::*;
#(
  parameter int W = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startI,
  output mulCtrlT ctrl,
  output logic    doneO
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

  mulStateT        state, stateNxt;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    ctrl     = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (startI) begin
          ctrl.load = 1'b1;
          stateNxt  = ST_RUN;
        end
      end
      ST_RUN: begin
        ctrl.step = 1'b1;
        if (stepCnt == LAST_STEP) stateNxt = ST_ACC;
      end
      ST_ACC: begin
        ctrl.finish = 1'b1;
        stateNxt    = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneO   <= 1'b0;
    end else begin
      state <= stateNxt;
      doneO <= ctrl.finish;
      if (ctrl.load)      stepCnt <= '0;
      else if (ctrl.step) stepCnt <= stepCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/boothMacDatapath.sv
module boothMacDatapath
  import boothMacPkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mulCtrlT      ctrl,
  input  logic         funcI,
  input  logic [W-1:0] opAI,
  input  logic [W-1:0] opBI,
  input  logic [W-1:0] accI,
  output logic [W-1:0] resultO
);
  logic [W-1:0] mcand;
  logic [W-1:0] mplier;
  logic         prevBit;
  logic [W-1:0] partial;
  logic [W-1:0] addReg;
  logic         macSel;
  logic [W-1:0] addend;

  boothRecode #(.W(W)) uRecode (
    .curBit (mplier[0]),
    .prevBit(prevBit),
    .mcand  (mcand),
    .addend (addend)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand   <= '0;
      mplier  <= '0;
      prevBit <= 1'b0;
      partial <= '0;
      addReg  <= '0;
      macSel  <= 1'b0;
      resultO <= '0;
    end else begin
      if (ctrl.load) begin
        mcand   <= opAI;
        mplier  <= opBI;
        prevBit <= 1'b0;
        partial <= '0;
        addReg  <= accI;
        macSel  <= funcI;
      end else if (ctrl.step) begin
        partial <= partial + addend;
        mcand   <= {mcand[W-2:0], 1'b0};
        mplier  <= {1'b0, mplier[W-1:1]};
        prevBit <= mplier[0];
      end
      if (ctrl.finish) begin
        resultO <= partial + (macSel ? addReg : '0);
      end
    end
  end
endmodule

// File: rtl/boothMac.sv
module boothMac
  import boothMacPkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startI,
  input  logic         funcI,
  input  logic [W-1:0] opAI,
  input  logic [W-1:0] opBI,
  input  logic [W-1:0] accI,
  output logic         doneO,
  output logic [W-1:0] resultO,
  output logic         flagNO,
  output logic         flagZO
);
  mulCtrlT ctrl;

  boothMacCtrl #(.W(W)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .startI(startI),
    .ctrl  (ctrl),
    .doneO (doneO)
  );

  boothMacDatapath #(.W(W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .funcI  (funcI),
    .opAI   (opAI),
    .opBI   (opBI),
    .accI   (accI),
    .resultO(resultO)
  );

  assign flagNO = resultO[W-1];
  assign flagZO = (resultO == '0);
endmodule

// File: rtl/boothMacChk.sv
module boothMacChk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         startI,
  input logic         funcI,
  input logic [W-1:0] opAI,
  input logic [W-1:0] opBI,
  input logic [W-1:0] accI,
  input logic         doneO,
  input logic [W-1:0] resultO
);
  localparam int LAT   = W + 2;
  localparam int CNT_W = $clog2(LAT + 1);
  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LAT);

  logic             chkBusy;
  logic [CNT_W-1:0] chkCnt;
  logic [W-1:0]     capA, capB, capAcc;
  logic             capMac;
  logic [W-1:0]     mulLow, expRes;
  logic             atEnd;

  assign atEnd  = chkBusy && (chkCnt == LAT_C);
  assign mulLow = capA * capB;
  assign expRes = mulLow + (capMac ? capAcc : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkBusy <= 1'b0;
      chkCnt  <= '0;
      capA    <= '0;
      capB    <= '0;
      capAcc  <= '0;
      capMac  <= 1'b0;
    end else if (startI && (!chkBusy || atEnd)) begin
      chkBusy <= 1'b1;
      chkCnt  <= CNT_W'(1);
      capA    <= opAI;
      capB    <= opBI;
      capAcc  <= accI;
      capMac  <= funcI;
    end else if (chkBusy) begin
      if (atEnd) chkBusy <= 1'b0;
      else       chkCnt  <= chkCnt + CNT_W'(1);
    end
  end

  // R4 R6
  done_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> atEnd);

  // R4 R10
  done_due_chk: assert property (@(posedge clk) disable iff (!rstN)
    atEnd |-> doneO);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO);

  // R2 R3
  product_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> (resultO == expRes));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(doneO) |-> $stable(resultO));
endmodule

bind boothMac boothMacChk #(.W(W)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .startI (startI),
  .funcI  (funcI),
  .opAI   (opAI),
  .opBI   (opBI),
  .accI   (accI),
  .doneO  (doneO),
  .resultO(resultO)
);

// File: tb/sim_boothMac.sv
`timescale 1ns/1ps
module sim_boothMac;
  localparam int W = 32;
  localparam int LAT = 34;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startI = 1'b0;
  logic         funcI = 1'b0;
  logic [W-1:0] opAI = '0, opBI = '0, accI = '0;
  logic         doneO;
  logic [W-1:0] resultO;
  logic         flagNO, flagZO;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  boothMac #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .startI(startI), .funcI(funcI),
    .opAI(opAI), .opBI(opBI), .accI(accI),
    .doneO(doneO), .resultO(resultO), .flagNO(flagNO), .flagZO(flagZO)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Drive a start on this negedge; deassert it at the next negedge.
  task automatic issue(input logic f, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [W-1:0] c);
    startI = 1'b1; funcI = f; opAI = a; opBI = b; accI = c;
    @(negedge clk);
    startI = 1'b0;
  endtask

  // Count edges (the start-sampling edge is edge 1) until doneO is seen.
  task automatic waitDone(output int edges);
    edges = 1;
    while (!doneO && edges < 200) begin
      @(negedge clk);
      edges++;
    end
  endtask

  function automatic logic [W-1:0] model(input logic f, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic [W-1:0] c);
    logic [W-1:0] p;
    p = a * b;
    return f ? p + c : p;
  endfunction

  task automatic runOp(input string tag, input logic f, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [W-1:0] c);
    int edges;
    logic [W-1:0] exp;
    exp = model(f, a, b, c);
    @(negedge clk);
    issue(f, a, b, c);
    waitDone(edges);
    check(edges == LAT, {tag, " R4 latency"}, W'(edges), W'(LAT));
    check(resultO == exp, {tag, " result"}, resultO, exp);
    check(flagNO == exp[W-1], {tag, " R7 N flag"}, W'(flagNO), W'(exp[W-1]));
    check(flagZO == (exp == '0), {tag, " R8 Z flag"}, W'(flagZO), W'(exp == '0));
    @(negedge clk);
    check(doneO == 1'b0, {tag, " R5 single pulse"}, W'(doneO), '0);
  endtask

  task automatic testReset();
    check(doneO == 1'b0, "R1 done", W'(doneO), '0);
    check(resultO == '0, "R1 result", resultO, '0);
    check(flagNO == 1'b0, "R1 N", W'(flagNO), '0);
    check(flagZO == 1'b1, "R1 Z", W'(flagZO), W'(1));
  endtask

  task automatic testMultiply();
    runOp("R2 small", 1'b0, 32'd7, 32'd6, 32'd0);
    runOp("R2 acc ignored", 1'b0, 32'd123, 32'd45, 32'hDEAD_BEEF);
    runOp("R2 negative", 1'b0, 32'hFFFF_FFFD, 32'd5, 32'd0);
    runOp("R2 both negative", 1'b0, 32'hFFFF_FF00, 32'hFFFF_FFF0, 32'd0);
    runOp("R2 wide", 1'b0, 32'h1234_5678, 32'h9ABC_DEF0, 32'd0);
    runOp("R2 alternating", 1'b0, 32'hA5A5_A5A5, 32'h5555_5555, 32'd0);
  endtask

  task automatic testMac();
    runOp("R3 mac", 1'b1, 32'd1000, 32'd2000, 32'd5);
    runOp("R3 mac negative", 1'b1, 32'h8000_0001, 32'd3, 32'h7000_0000);
  endtask

  task automatic testZero();
    runOp("R8 zero operand", 1'b0, 32'd0, 32'hFFFF_FFFF, 32'd0);
    runOp("R8 wrap to zero", 1'b1, 32'hFFFF_FFFF, 32'd1, 32'd1);
  endtask

  task automatic testBusyIgnored();
    int edges;
    logic [W-1:0] exp;
    exp = model(1'b0, 32'd11, 32'd13, 32'd0);
    @(negedge clk);
    issue(1'b0, 32'd11, 32'd13, 32'd0);
    edges = 1;
    repeat (9) begin @(negedge clk); edges++; end
    startI = 1'b1; funcI = 1'b1; opAI = 32'd99; opBI = 32'd77; accI = 32'd1;
    @(negedge clk); edges++;
    startI = 1'b0;
    while (!doneO && edges < 200) begin @(negedge clk); edges++; end
    check(edges == LAT, "R6 timing kept", W'(edges), W'(LAT));
    check(resultO == exp, "R6 first operands used", resultO, exp);
    begin
      int extra = 0;
      repeat (60) begin
        @(negedge clk);
        if (doneO) extra++;
      end
      check(extra == 0, "R6 no second done", W'(extra), '0);
    end
    check(resultO == exp, "R9 result held", resultO, exp);
  endtask

  task automatic testBackToBack();
    int edges;
    logic [W-1:0] exp1, exp2;
    exp1 = model(1'b1, 32'd3, 32'd4, 32'd10);
    exp2 = model(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0);
    @(negedge clk);
    issue(1'b1, 32'd3, 32'd4, 32'd10);
    waitDone(edges);
    check(resultO == exp1, "R10 first result", resultO, exp1);
    issue(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0);
    edges = 1;
    check(resultO == exp1, "R9 held during next op", resultO, exp1);
    while (!doneO && edges < 200) begin @(negedge clk); edges++; end
    check(edges == LAT, "R10 latency", W'(edges), W'(LAT));
    check(resultO == exp2, "R10 second result", resultO, exp2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testMultiply();
    testMac();
    testZero();
    testBusyIgnored();
    testBackToBack();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #160000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule